// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This controller decides when the contents of a fast volatile memory are copied to, or reloaded from, a nonvolatile shadow array around supply events. Two digital comparator flags report the supply state: one is high while the supply sits under the switch threshold, the other while it sits under the lower reset threshold. A write-occurred pulse from the memory port marks the array as modified. The controller then issues store and recall start pulses, drives an active-low store-busy line, disables the memory while a nonvolatile cycle runs and blocks writes whenever they would be unsafe.

A supply drop through the switch level opens a short busy window, after which a store starts only when the array was modified since the last nonvolatile cycle. A drop that also crosses the reset level latches a recall request, which runs when the supply climbs back over the switch level. The recall runs for a fixed number of cycles, split into a clear phase and a load phase. A store's duration is set by an external done pulse. A parameter turns off the automatic store on supply loss, leaving recall and write blocking unchanged.

Top module: `pfs_seq`

## Requirements
- R1: While reset is asserted, busy_n is 1, store_start, recall_start and sram_dis are 0 and, with the supply above switch level, wr_inhibit is 0. Reset leaves the modified flag clear and a recall request pending.
- R2: With a recall pending and supply above the switch level, the sequencer in idle raises recall_start for one cycle and holds sram_dis high for RESTORE_CYC cycles starting in that same cycle.
- R3: During a recall, recall_clr is high for the first CLEAR_CYC cycles and recall_load for the remaining RESTORE_CYC-CLEAR_CYC cycles; never both.
- R4: A supply level under the reset threshold latches a recall request; a dip under the switch level alone causes no recall on return.
- R5: On a fall through the switch level with the array modified, busy_n goes low for BUSY_CYC cycles, then store_start pulses; busy_n and sram_dis stay asserted until store_done, and busy_n returns to 1 the cycle after it.
- R6: On a fall through the switch level with the array unmodified, busy_n is low for BUSY_CYC cycles, then released with no store_start.
- R7: wr_inhibit is high whenever the supply is under the switch level or the sequencer is not idle; write pulses while it is high do not mark the array modified.
- R8: A completed store and a completed recall each clear the modified flag.
- R9: A hw_store_req pulse starts a store only when idle, above the switch level and modified; otherwise it is ignored.
- R10: With AUTO_INHIBIT set, a fall through the switch level never lowers busy_n nor starts a store, while recall on return from a reset-level dip still runs.
- R11: A supply return during the busy window cancels it (busy_n 1 next cycle, no store); a started store keeps busy_n low until store_done even after the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_sw | input | 1 | Supply under switch threshold |
| below_rst | input | 1 | Supply under reset threshold |
| wr_pulse | input | 1 | A memory write occurred this cycle |
| hw_store_req | input | 1 | External store request pulse |
| store_done | input | 1 | Nonvolatile store finished |
| store_start | output | 1 | One-cycle store start request |
| recall_start | output | 1 | One-cycle recall start request |
| busy_n | output | 1 | Active-low store busy |
| sram_dis | output | 1 | Memory disabled for a nonvolatile cycle |
| wr_inhibit | output | 1 | Memory writes blocked |
| recall_clr | output | 1 | Recall clear phase |
| recall_load | output | 1 | Recall load phase |

## Verification
The assertions assume the comparator flags are consistent, so below_rst is never high without below_sw, and that store_done only arrives while a store is running. The stimulus raises and drops below_rst only while below_sw is held, and pulses store_done only after a store_start was seen. Write pulses are applied both in allowed and blocked states, and supply returns are swept over every position inside the busy window.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RECALL = 3'd1,
    ST_WIN    = 3'd2,
    ST_STORE  = 3'd3,
    ST_LOW    = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_timer.sv
module pfs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pfs_flags.sv
module pfs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  input  logic wr_ok,
  input  logic dirty_clr,
  input  logic pend_set,
  input  logic pend_clr,
  output logic dirty,
  output logic pend
);
  logic dirty_q, dirty_d, pend_q, pend_d;

  always_comb begin
    dirty_d = dirty_q;
    if (dirty_clr)          dirty_d = 1'b0;
    else if (wr_set && wr_ok) dirty_d = 1'b1;
    pend_d = pend_q;
    if (pend_set)      pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      dirty_q <= dirty_d;
      pend_q  <= pend_d;
    end
  end

  // R7
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !dirty_q) |=> !dirty_q);

  assign dirty = dirty_q;
  assign pend  = pend_q;
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq #(
  parameter int BUSY_CYC     = 4,
  parameter int RESTORE_CYC  = 6,
  parameter int CLEAR_CYC    = 2,
  parameter bit AUTO_INHIBIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_sw,
  input  logic below_rst,
  input  logic wr_pulse,
  input  logic hw_store_req,
  input  logic store_done,
  output logic store_start,
  output logic recall_start,
  output logic busy_n,
  output logic sram_dis,
  output logic wr_inhibit,
  output logic recall_clr,
  output logic recall_load
);
  import pfs_pkg::*;

  localparam int MAXC = (RESTORE_CYC > BUSY_CYC) ? RESTORE_CYC : BUSY_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pfs_state_e   st_q, st_d;
  logic [CW-1:0] cnt;
  logic          dirty, pend;
  logic          sstart_q, rstart_q;
  logic          win_end, rec_end;
  logic          fall_tgt;

  assign win_end = (cnt == CW'(BUSY_CYC - 1));
  assign rec_end = (cnt == CW'(RESTORE_CYC - 1));

  generate
    if (AUTO_INHIBIT) begin : g_noauto
      assign fall_tgt = 1'b1;
    end else begin : g_auto
      assign fall_tgt = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (below_sw)                   st_d = fall_tgt ? ST_LOW : ST_WIN;
        else if (pend)                  st_d = ST_RECALL;
        else if (hw_store_req && dirty) st_d = ST_STORE;
      end
      ST_WIN: begin
        if (!below_sw)    st_d = ST_IDLE;
        else if (win_end) st_d = dirty ? ST_STORE : ST_LOW;
      end
      ST_STORE: if (store_done) st_d = below_sw ? ST_LOW : ST_IDLE;
      ST_LOW:   if (!below_sw)  st_d = ST_IDLE;
      ST_RECALL: if (rec_end)   st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sstart_q <= 1'b0;
      rstart_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sstart_q <= (st_d == ST_STORE)  && (st_q != ST_STORE);
      rstart_q <= (st_d == ST_RECALL) && (st_q != ST_RECALL);
    end
  end

  pfs_timer #(.W(CW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st_d != st_q),
    .cnt  (cnt)
  );

  pfs_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (wr_pulse),
    .wr_ok    (!wr_inhibit),
    .dirty_clr((st_q == ST_STORE && store_done) || (st_q == ST_RECALL && rec_end)),
    .pend_set (below_rst),
    .pend_clr (st_q == ST_IDLE && st_d == ST_RECALL),
    .dirty    (dirty),
    .pend     (pend)
  );

  assign store_start  = sstart_q;
  assign recall_start = rstart_q;
  assign busy_n       = !(st_q == ST_WIN || st_q == ST_STORE);
  assign sram_dis     = (st_q == ST_RECALL) || (st_q == ST_STORE);
  assign wr_inhibit   = below_sw || (st_q != ST_IDLE);
  assign recall_clr   = (st_q == ST_RECALL) && (cnt <  CW'(CLEAR_CYC));
  assign recall_load  = (st_q == ST_RECALL) && (cnt >= CW'(CLEAR_CYC));

  // R5
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> $past(dirty));
  // R2
  recall_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> $past(pend));
  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({recall_clr, recall_load}));
  // R11
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && sram_dis && !store_done) |=> !busy_n);
  // R8
  recall_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recall_load) |-> !dirty);
endmodule

// File: tb/sim_pfs_seq.sv
module sim_pfs_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic below_sw, below_rst, wr_pulse, hw_req, hw_req1, store_done;
  logic s0, r0, b0, d0, w0, c0, l0;
  logic s1, r1, b1, d1, w1, c1, l1;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  pfs_seq #(.BUSY_CYC(4), .RESTORE_CYC(6), .CLEAR_CYC(2), .AUTO_INHIBIT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .below_sw(below_sw), .below_rst(below_rst),
    .wr_pulse(wr_pulse), .hw_store_req(hw_req), .store_done(store_done),
    .store_start(s0), .recall_start(r0), .busy_n(b0), .sram_dis(d0),
    .wr_inhibit(w0), .recall_clr(c0), .recall_load(l0));

  pfs_seq #(.BUSY_CYC(4), .RESTORE_CYC(6), .CLEAR_CYC(2), .AUTO_INHIBIT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .below_sw(below_sw), .below_rst(below_rst),
    .wr_pulse(wr_pulse), .hw_store_req(hw_req1), .store_done(store_done),
    .store_start(s1), .recall_start(r1), .busy_n(b1), .sram_dis(d1),
    .wr_inhibit(w1), .recall_clr(c1), .recall_load(l1));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_once();
    wr_pulse = 1'b1; tick(); wr_pulse = 1'b0;
  endtask

  task automatic done_pulse();
    store_done = 1'b1; tick(); store_done = 1'b0;
  endtask

  task automatic fall_measure(output int nb, output int st);
    below_sw = 1'b1; nb = 0; st = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (s0) begin st = 1; break; end
      if (!b0) nb++;
      else if (nb > 0) break;
    end
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int nb, st, cnt_c, cnt_l, cnt_d, ra, rb, lows;
    rst_n = 1'b0; below_sw = 0; below_rst = 0; wr_pulse = 0;
    hw_req = 0; hw_req1 = 0; store_done = 0;
    tick(3);
    // R1 reset state
    chk("R1 busy_n", b0, 1); chk("R1 store_start", s0, 0);
    chk("R1 recall_start", r0, 0); chk("R1 sram_dis", d0, 0);
    chk("R1 wr_inhibit", w0, 0);
    rst_n = 1'b1;
    tick();
    // R1/R2 power-up recall pending after reset
    chk("R2 recall_start", r0, 1); chk("R2 recall_start u1", r1, 1);
    chk("R7 wr_inhibit in recall", w0, 1);
    cnt_c = 0; cnt_l = 0; cnt_d = 0;
    for (int i = 0; i < 10; i++) begin
      if (!d0) break;
      cnt_d++;
      if (c0) cnt_c++;
      if (l0) cnt_l++;
      if (c0 && cnt_l > 0) chk("R3 clear after load", 1, 0);
      tick();
    end
    chk("R2 sram_dis length", cnt_d, 6);
    chk("R3 clear length", cnt_c, 2);
    chk("R3 load length", cnt_l, 4);
    chk("R2 recall_start single", r0, 0);
    tick(2);

    // R5 / R6 sweep over modified state
    for (int d = 0; d < 2; d++) begin
      if (d == 1) write_once();
      fall_measure(nb, st);
      chk(d ? "R5 busy window" : "R6 busy window", nb, 4);
      chk(d ? "R5 store started" : "R6 no store", st, d);
      if (d == 1) begin
        chk("R5 sram_dis in store", d0, 1);
        tick(3);
        chk("R5 busy held", b0, 0);
        done_pulse();
        chk("R5 busy release", b0, 1);
        below_sw = 0; tick();
        ra = 0;
        for (int i = 0; i < 4; i++) begin tick(); if (r0) ra++; end
        chk("R4 shallow dip no recall", ra, 0);
        fall_measure(nb, st);
        chk("R8 store clears modified", st, 0);
      end
      below_sw = 0; tick(2);
    end

    // R7 writes blocked under switch level
    chk("R7 wr_inhibit idle", w0, 0);
    below_sw = 1; tick();
    chk("R7 wr_inhibit low supply", w0, 1);
    write_once(); tick(6);
    below_sw = 0; tick(2);
    fall_measure(nb, st);
    chk("R7 blocked write ignored", st, 0);
    below_sw = 0; tick(2);

    // R11 cancel sweep over every window position
    for (int k = 1; k <= 4; k++) begin
      write_once();
      below_sw = 1; tick(k);
      chk("R11 busy in window", b0, 0);
      below_sw = 0; tick();
      chk("R11 cancel busy", b0, 1);
      chk("R11 cancel no store", s0, 0);
      tick(2);
      chk("R11 no late store", s0, 0);
    end
    fall_measure(nb, st);
    chk("R11 store started", st, 1);
    below_sw = 0; tick(3);
    chk("R11 store continues", b0, 0);
    done_pulse();
    chk("R11 store end", b0, 1);
    tick(2);

    // R9 external request
    hw_req = 1; tick(); hw_req = 0;
    chk("R9 clean request ignored", s0, 0);
    tick(2); chk("R9 clean request ignored later", b0, 1);
    write_once();
    hw_req = 1; tick(); hw_req = 0;
    chk("R9 request honoured", s0, 1);
    chk("R9 busy", b0, 0);
    done_pulse();
    chk("R9 busy release", b0, 1);
    tick(2);
    // R9 blocked under switch level (auto store off instance)
    below_sw = 1; hw_req1 = 1; tick(2); hw_req1 = 0;
    chk("R9 blocked low supply", s1, 0);
    tick(6); below_sw = 0; tick(2);
    hw_req1 = 1; tick(); hw_req1 = 0;
    chk("R9 request honoured u1", s1, 1);
    done_pulse(); tick();

    // R4 / R10 deep dip
    write_once();
    below_sw = 1; below_rst = 1; lows = 0;
    for (int i = 0; i < 8; i++) begin tick(); if (!b1) lows++; end
    chk("R10 no busy window", lows, 0);
    chk("R10 no store", s1, 0);
    done_pulse();
    below_rst = 0; tick(); below_sw = 0;
    ra = 0; rb = 0;
    for (int i = 0; i < 6; i++) begin tick(); if (r0) ra++; if (r1) rb++; end
    chk("R4 deep dip recall", ra, 1);
    chk("R10 recall kept", rb, 1);
    tick(8);
    hw_req1 = 1; tick(); hw_req1 = 0;
    chk("R8 recall clears modified", s1, 0);
    tick(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule